// File: doc/BRIEF.md
# Video-Line Read Command Scheduler

This block decides when a display-link host may send a low-power read command to a peripheral while video keeps streaming. Each line has a low-power window. The read can be sent in that window only when its worst-case duration fits inside it. The duration is given in lane byte clock cycles. It includes the HS/LP transitions, the escape-mode and low-power data overhead, the read command itself (64 escape cycles), the time for the peripheral to return data, and two bus turnarounds. The window size is given in units of 16 escape clock periods. The block compares the two with an integer cross-multiplication against the programmed byte and escape clock periods, so no divider is needed.

A request is accepted with a single-cycle handshake. On acceptance, the current read-duration setting is captured for that read. At every line start the block evaluates the fit rule. A fitting read is dispatched at the first line start after it was accepted. A read that does not fit waits for the line start flagged as the last line of the frame. It is dispatched there, and a halt is raised toward the pixel source. The halt holds until the peripheral's read-complete pulse arrives. Only one read is outstanding at a time.

Top module: `rd_line_sched`

## Requirements
- R1: After reset, `rd_issue_o`, `halt_o` and `line_fit_o` are 0, and the block is idle, so a request is acknowledged.
- R2: `rd_ack_o` is high combinationally, in the same cycle as `rd_req_i`, exactly when no read is pending or in progress. An acknowledged read becomes pending at the next edge.
- R3: The value of `cfg_max_rd_i` is captured in the cycle of acknowledgement. Later changes to it do not affect the dispatch decision of the read already accepted.
- R4: A read fits when `max_rd * byte_per < lp_size * 16 * esc_per`, compared as unsigned integers. Equality does not fit.
- R5: A pending read that fits is dispatched at the first `line_start_i` pulse sampled after acknowledgement. `rd_issue_o` is high for exactly the one cycle after that edge, and `halt_o` stays 0.
- R6: A pending read that does not fit ignores line starts while `last_line_i` is 0. At a line start with `last_line_i` = 1, it is dispatched: `rd_issue_o` pulses for one cycle, and `halt_o` rises in the same cycle.
- R7: `halt_o` stays high until `rd_done_i` is sampled. It is 0 in the cycle after that edge.
- R8: While a read is pending or in progress, `rd_ack_o` stays 0. Once `rd_done_i` ends an issued read, a request is acknowledged again from the next cycle on.
- R9: At each `line_start_i` edge, `line_fit_o` loads the result of the R4 rule for the last captured read duration and the current window and period settings. It holds between line starts.
- R10: A `rd_done_i` pulse while no read has been issued is ignored. A pending read stays pending, and an idle block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse at the start of each video line |
| last_line_i | input | 1 | High while the current line start is the frame's last line |
| cfg_max_rd_i | input | MAX_W | Worst-case read duration in byte clock cycles |
| cfg_lp_size_i | input | LP_W | Per-line low-power window, in units of 16 escape periods |
| cfg_byte_per_i | input | PER_W | Byte clock period in common time units |
| cfg_esc_per_i | input | PER_W | Escape clock period in common time units |
| rd_req_i | input | 1 | Read request |
| rd_ack_o | output | 1 | Request accepted this cycle |
| rd_done_i | input | 1 | Read-complete pulse from the link |
| rd_issue_o | output | 1 | One-cycle pulse: send the read command now |
| halt_o | output | 1 | Stall toward the pixel source during a last-line read |
| line_fit_o | output | 1 | Fit result registered at the latest line start |

## Verification
A wrong captured duration or wrong comparison width shows at the first line start after acknowledgement. `rd_issue_o` then fires on an ordinary line when it should wait, or waits when it should fire, and `line_fit_o` disagrees one cycle after the same edge. A sequencer stuck in its busy or halted state shows as a `halt_o` that outlives `rd_done_i` by more than one cycle, or as a missing acknowledgement on the next request. A busy state that is lost shows as `rd_ack_o` rising while a read is still outstanding.

// File: rtl/rdsched_pkg.sv
package rdsched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PEND   = 2'd1,
    ST_INLINE = 2'd2,
    ST_LAST   = 2'd3
  } rd_state_e;

  localparam int unsigned ESC_UNIT_SHIFT = 4; // window counted in 16 escape periods
endpackage

// File: rtl/rdsched_budget.sv
module rdsched_budget #(
  parameter int unsigned MAX_W = 16,
  parameter int unsigned LP_W  = 8,
  parameter int unsigned PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic [MAX_W-1:0] max_rd_i,
  input  logic [LP_W-1:0]  lp_size_i,
  input  logic [PER_W-1:0] byte_per_i,
  input  logic [PER_W-1:0] esc_per_i,
  output logic             fit_o,
  output logic             line_fit_o
);
  import rdsched_pkg::*;

  localparam int unsigned LHS_W = MAX_W + PER_W;
  localparam int unsigned RHS_W = LP_W + ESC_UNIT_SHIFT + PER_W;
  localparam int unsigned CMP_W = (LHS_W > RHS_W) ? LHS_W : RHS_W;

  logic [CMP_W-1:0] lhs, rhs;

  // cross-multiplied durations in common time units
  assign lhs   = CMP_W'(max_rd_i) * CMP_W'(byte_per_i);
  assign rhs   = (CMP_W'(lp_size_i) << ESC_UNIT_SHIFT) * CMP_W'(esc_per_i);
  assign fit_o = lhs < rhs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           line_fit_o <= 1'b0;
    else if (line_start_i) line_fit_o <= fit_o;
  end

  AST_FIT_SAMPLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> line_fit_o == $past(fit_o)); // R9
  AST_FIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(line_fit_o)); // R9
endmodule

// File: rtl/rdsched_req.sv
module rdsched_req #(
  parameter int unsigned MAX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic             idle_i,
  input  logic [MAX_W-1:0] cfg_max_rd_i,
  output logic             rd_ack_o,
  output logic [MAX_W-1:0] max_rd_q_o
);
  assign rd_ack_o = rd_req_i & idle_i;

  // budget captured per read; later writes wait for the next read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       max_rd_q_o <= '0;
    else if (rd_ack_o) max_rd_q_o <= cfg_max_rd_i;
  end

  AST_BUDGET_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(max_rd_q_o)); // R3
endmodule

// File: rtl/rdsched_fsm.sv
module rdsched_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  input  logic line_start_i,
  input  logic last_line_i,
  input  logic fit_i,
  input  logic rd_done_i,
  output logic idle_o,
  output logic rd_issue_o,
  output logic halt_o
);
  import rdsched_pkg::*;

  rd_state_e state_q, state_d;
  logic      issue_d;

  always_comb begin
    state_d = state_q;
    issue_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ack_i) state_d = ST_PEND;
      ST_PEND: begin
        if (line_start_i) begin
          if (fit_i) begin
            state_d = ST_INLINE;
            issue_d = 1'b1;
          end else if (last_line_i) begin
            state_d = ST_LAST;
            issue_d = 1'b1;
          end
        end
      end
      ST_INLINE, ST_LAST: if (rd_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rd_issue_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_issue_o <= issue_d;
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign halt_o = (state_q == ST_LAST);

  AST_ACK_TO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> state_q == ST_PEND); // R2
  AST_ISSUE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issue_o |=> !rd_issue_o); // R5
  AST_ISSUE_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issue_o |-> $past(line_start_i)); // R5
  AST_INLINE_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_issue_o && !halt_o) |-> $past(fit_i)); // R4
  AST_HALT_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> (rd_issue_o && $past(last_line_i))); // R6
  AST_HALT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && rd_done_i) |=> !halt_o); // R7
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !rd_done_i) |=> halt_o); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |-> !ack_i); // R8
endmodule

// File: rtl/rd_line_sched.sv
module rd_line_sched #(
  parameter int unsigned MAX_W = 16,
  parameter int unsigned LP_W  = 8,
  parameter int unsigned PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic             last_line_i,
  input  logic [MAX_W-1:0] cfg_max_rd_i,
  input  logic [LP_W-1:0]  cfg_lp_size_i,
  input  logic [PER_W-1:0] cfg_byte_per_i,
  input  logic [PER_W-1:0] cfg_esc_per_i,
  input  logic             rd_req_i,
  output logic             rd_ack_o,
  input  logic             rd_done_i,
  output logic             rd_issue_o,
  output logic             halt_o,
  output logic             line_fit_o
);
  logic             idle;
  logic             fit;
  logic [MAX_W-1:0] max_rd_q;

  rdsched_req #(.MAX_W(MAX_W)) u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_req_i     (rd_req_i),
    .idle_i       (idle),
    .cfg_max_rd_i (cfg_max_rd_i),
    .rd_ack_o     (rd_ack_o),
    .max_rd_q_o   (max_rd_q)
  );

  rdsched_budget #(.MAX_W(MAX_W), .LP_W(LP_W), .PER_W(PER_W)) u_budget (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .max_rd_i     (max_rd_q),
    .lp_size_i    (cfg_lp_size_i),
    .byte_per_i   (cfg_byte_per_i),
    .esc_per_i    (cfg_esc_per_i),
    .fit_o        (fit),
    .line_fit_o   (line_fit_o)
  );

  rdsched_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ack_i        (rd_ack_o),
    .line_start_i (line_start_i),
    .last_line_i  (last_line_i),
    .fit_i        (fit),
    .rd_done_i    (rd_done_i),
    .idle_o       (idle),
    .rd_issue_o   (rd_issue_o),
    .halt_o       (halt_o)
  );
endmodule

// File: tb/rd_line_sched_test.sv
module rd_line_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0, last_line = 1'b0;
  logic [15:0] cfg_max = '0;
  logic [7:0]  cfg_lp = '0, cfg_bp = '0, cfg_ep = '0;
  logic        rd_req = 1'b0, rd_done = 1'b0;
  logic        rd_ack, rd_issue, halt, line_fit;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rd_line_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .last_line_i(last_line),
    .cfg_max_rd_i(cfg_max), .cfg_lp_size_i(cfg_lp), .cfg_byte_per_i(cfg_bp),
    .cfg_esc_per_i(cfg_ep), .rd_req_i(rd_req), .rd_ack_o(rd_ack), .rd_done_i(rd_done),
    .rd_issue_o(rd_issue), .halt_o(halt), .line_fit_o(line_fit)
  );

  function automatic bit fits(int unsigned m, int unsigned lp, int unsigned bp, int unsigned ep);
    longint unsigned l, r;
    l = longint'(m) * bp;
    r = longint'(lp) * 16 * ep;
    return l < r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // pulse one line start; outputs checked one cycle after the sampling edge
  task automatic line(bit last);
    line_start = 1'b1; last_line = last;
    step();
    line_start = 1'b0; last_line = 1'b0;
  endtask

  // one full read transaction; nl = lines before forced last line
  task automatic do_read(int unsigned m, int unsigned lp, int unsigned bp, int unsigned ep,
                         int unsigned nl, bit stray_done, bit rewrite);
    bit ef, issued;
    cfg_max = 16'(m); cfg_lp = 8'(lp); cfg_bp = 8'(bp); cfg_ep = 8'(ep);
    ef = fits(m, lp, bp, ep);
    rd_req = 1'b1; #1;
    chk(rd_ack === 1'b1, "R2 ack when idle", rd_ack, 1);
    step();
    rd_req = 1'b0;
    if (rewrite) cfg_max = (m > 100) ? 16'd0 : 16'hFFFF; // R3: must not change decision
    if (stray_done) begin
      rd_done = 1'b1; step(); rd_done = 1'b0;
    end
    rd_req = 1'b1; #1;
    chk(rd_ack === 1'b0, "R8 no ack while pending", rd_ack, 0);
    rd_req = 1'b0;
    issued = 0;
    for (int i = 0; i <= int'(nl) && !issued; i++) begin
      bit last = (i == int'(nl)) || ($urandom_range(0, 5) == 0);
      step();
      line(last);
      chk(line_fit === ef, "R9 line fit", line_fit, ef);
      if (ef) begin
        chk(rd_issue === 1'b1, "R5 in-line issue", rd_issue, 1);
        chk(halt === 1'b0, "R5 no halt in-line", halt, 0);
        issued = 1;
      end else if (last) begin
        chk(rd_issue === 1'b1, "R6 last-line issue", rd_issue, 1);
        chk(halt === 1'b1, "R6 halt on last line", halt, 1);
        issued = 1;
      end else begin
        chk(rd_issue === 1'b0, "R6 wait on ordinary line", rd_issue, 0);
        chk(halt === 1'b0, "R6 no halt while waiting", halt, 0);
      end
    end
    step();
    chk(rd_issue === 1'b0, "R5 single issue pulse", rd_issue, 0);
    for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
      chk(halt === !ef, "R7 halt held", halt, !ef);
      rd_req = 1'b1; #1;
      chk(rd_ack === 1'b0, "R8 no ack while busy", rd_ack, 0);
      rd_req = 1'b0;
      step();
    end
    chk(halt === !ef, "R7 halt before done", halt, !ef);
    rd_done = 1'b1; step(); rd_done = 1'b0;
    chk(halt === 1'b0, "R7 halt released", halt, 0);
    rd_req = 1'b1; #1;
    chk(rd_ack === 1'b1, "R8 ack after done", rd_ack, 1);
    rd_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    step(); step();
    rst_n = 1'b1;
    step();
    chk(rd_issue === 1'b0, "R1 issue reset", rd_issue, 0);
    chk(halt === 1'b0, "R1 halt reset", halt, 0);
    chk(line_fit === 1'b0, "R1 line fit reset", line_fit, 0);
    rd_req = 1'b1; #1;
    chk(rd_ack === 1'b1, "R1 idle after reset", rd_ack, 1);
    rd_req = 1'b0;
    // R10: stray done while idle
    rd_done = 1'b1; step(); rd_done = 1'b0;
    rd_req = 1'b1; #1;
    chk(rd_ack === 1'b1, "R10 idle after stray done", rd_ack, 1);
    rd_req = 1'b0;
    // R4 boundary: 64*1 vs 4*16*1
    do_read(64, 4, 1, 1, 2, 0, 0);
    do_read(63, 4, 1, 1, 2, 0, 0);
    do_read(65535, 255, 255, 1, 1, 0, 0);
    do_read(0, 1, 1, 1, 1, 0, 0);
    // R3: rewrite after acceptance; R10: stray done while pending
    do_read(500, 10, 2, 8, 3, 1, 1);
    do_read(50, 10, 2, 8, 3, 1, 1);
    for (int t = 0; t < 300; t++) begin
      do_read($urandom_range(0, 2000), $urandom_range(0, 40), $urandom_range(1, 8),
              $urandom_range(1, 8), $urandom_range(0, 4), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
    end
    step();
    summary();
  end
endmodule